// File: doc/BRIEF.md
# DMA Channel Transfer-Mode Sequencer

This block is the control sequencer for a single DMA channel. Software writes a configuration word that holds a 3-bit transfer mode, an enable bit, a transfer count and a line length. The mode decides three things. The first is what starts a burst: a peripheral request, or the enable bit alone. The second is how many words one trigger moves: a single word, one line, or everything up to terminal count. The third is whether the enable bit clears itself when the count runs out.

The sequencer issues one-word transfer strobes on a valid/ready port toward a simple memory-move engine. `xfer_valid` rises when a word is due. Once raised it stays high until a cycle in which `xfer_ready` is also high. That cycle is the handshake, and exactly one word moves in it. The engine can apply back-pressure for as long as it needs by holding `xfer_ready` low. The sequencer then waits, and no word is dropped or counted twice. The control and status pins are plain levels.

A programmed count of N moves N+1 words before terminal count. At terminal count the counter reloads the programmed value. An end-of-block interrupt pulse is raised when the mode allows it.

Top module: `dma_mode_seq`

## Requirements
- R1: After reset the enable bit reads 0, the counter reads 0, `xfer_valid` is low, `irq_eob` is low, and the stored mode is 000.
- R2: Once `xfer_valid` is high it stays high until a cycle with `xfer_ready` high. Each such handshake moves exactly one word and decrements the counter by one, or reloads the programmed count when the counter was already 0 (terminal count).
- R3: Mode 000: after enable, a single request runs N+1 words back to back. At terminal count the counter reloads and the enable bit clears. A request seen while the enable bit is 0 is discarded.
- R4: Mode 001: each request moves one word. The word taken at terminal count reloads the counter and clears the enable bit, so requests after that move nothing.
- R5: Mode 010: each request moves `cfg_line`+1 words, or fewer if terminal count comes first. At terminal count the counter reloads and the enable bit clears.
- R6: Mode 011: setting the enable bit alone starts N+1 words with no request. Terminal count reloads the counter and clears the enable bit.
- R7: Mode 100: each request after enable runs one full block of N+1 words. Terminal count reloads the counter and leaves the enable bit set, so later requests run further blocks.
- R8: Mode 101: each request moves one word. The enable bit stays set across terminal count, and after W words the counter reads N - (W mod (N+1)).
- R9: Modes 110 and 111 never raise `xfer_valid`. Requests leave the enable bit and the counter unchanged.
- R10: In modes 001 and 101, one request that arrives while a word is in service is held pending and served after it. In modes 000, 010 and 100, a request that arrives while a burst is active is dropped.
- R11: `irq_eob` is a one-cycle pulse in the cycle after the terminal-count handshake. It fires only in modes 000 to 011 and only while `irq_en` is 1.
- R12: Writing enable=0 during a transfer clears the enable bit at once. The word in service still completes with its handshake, no further word is issued, a pending request is discarded, and the counter keeps its decremented value without a reload.
- R13: A write with enable=1 loads mode, count and line length only when the channel is disabled and idle. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable bit value written |
| cfg_mode | input | 3 | Transfer mode written |
| cfg_count | input | CNT_W | Transfer count N (N+1 words per block) |
| cfg_line | input | LINE_W | Line length minus one, used in mode 010 |
| irq_en | input | 1 | End-of-block interrupt enable |
| req | input | 1 | Peripheral request, sampled each cycle |
| xfer_valid | output | 1 | A one-word transfer is due |
| xfer_ready | input | 1 | Memory-move port accepts the word |
| en_o | output | 1 | Current enable bit |
| count_o | output | CNT_W | Current counter value |
| irq_eob | output | 1 | End-of-block interrupt pulse |

## Verification
The bench sweeps every mode against small counts, both line lengths, both interrupt-enable settings, and free-flowing or stalled ready. A wrong terminal test would show up as N words instead of N+1. A wrong mode decode would show up as an enable bit that clears in a repeating mode, or an interrupt in a suppressed mode. Directed cases cover the following:
- Two requests on consecutive cycles: a lost pending request in the word modes would give one word, and a wrongly kept request in the block modes would give two blocks.
- An abort while the port is stalled: a design that drops the held word, or reloads on abort, would show up at the ports.
- Requests or configuration writes that must be ignored.
- The exact cycle of the interrupt pulse.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam logic [2:0] MODE_BLK_REQ   = 3'b000;
  localparam logic [2:0] MODE_WORD_REQ  = 3'b001;
  localparam logic [2:0] MODE_LINE_REQ  = 3'b010;
  localparam logic [2:0] MODE_BLK_EN    = 3'b011;
  localparam logic [2:0] MODE_BLK_RPT   = 3'b100;
  localparam logic [2:0] MODE_WORD_RPT  = 3'b101;

  typedef enum logic [1:0] {
    GRAN_WORD  = 2'd0,
    GRAN_LINE  = 2'd1,
    GRAN_BLOCK = 2'd2
  } gran_e;

  typedef struct packed {
    logic  legal;     // mode performs transfers
    logic  req_trig;  // bursts start on a request
    logic  auto_clr;  // enable clears at terminal count
    logic  two_pend;  // one request may wait behind a busy word
    gran_e gran;
  } mode_attr_t;

  function automatic mode_attr_t decode_mode(input logic [2:0] m);
    mode_attr_t a;
    a = '{legal: 1'b0, req_trig: 1'b0, auto_clr: 1'b0, two_pend: 1'b0, gran: GRAN_BLOCK};
    case (m)
      MODE_BLK_REQ:  a = '{legal: 1'b1, req_trig: 1'b1, auto_clr: 1'b1, two_pend: 1'b0, gran: GRAN_BLOCK};
      MODE_WORD_REQ: a = '{legal: 1'b1, req_trig: 1'b1, auto_clr: 1'b1, two_pend: 1'b1, gran: GRAN_WORD};
      MODE_LINE_REQ: a = '{legal: 1'b1, req_trig: 1'b1, auto_clr: 1'b1, two_pend: 1'b0, gran: GRAN_LINE};
      MODE_BLK_EN:   a = '{legal: 1'b1, req_trig: 1'b0, auto_clr: 1'b1, two_pend: 1'b0, gran: GRAN_BLOCK};
      MODE_BLK_RPT:  a = '{legal: 1'b1, req_trig: 1'b1, auto_clr: 1'b0, two_pend: 1'b0, gran: GRAN_BLOCK};
      MODE_WORD_RPT: a = '{legal: 1'b1, req_trig: 1'b1, auto_clr: 1'b0, two_pend: 1'b1, gran: GRAN_WORD};
      default:       a = '{legal: 1'b0, req_trig: 1'b0, auto_clr: 1'b0, two_pend: 1'b0, gran: GRAN_BLOCK};
    endcase
    return a;
  endfunction

endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  output mode_attr_t attr_o
);

  always_comb attr_o = decode_mode(mode_i);

  // R9
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:1] == 2'b11) |-> (!attr_o.legal && !attr_o.auto_clr));

  // R10
  pend_word_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attr_o.two_pend |-> (attr_o.gran == GRAN_WORD));

endmodule

// File: rtl/dma_req_latch.sv
module dma_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic legal_i,
  input  logic req_trig_i,
  input  logic two_pend_i,
  input  logic busy_i,
  input  logic start_i,
  input  logic req_i,
  output logic pend_o
);

  logic pend_q;
  logic armed;

  assign armed = en_i && legal_i && req_trig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (!armed) begin
      pend_q <= 1'b0;
    end else if (start_i) begin
      // a stored request is consumed; a fresh one in the same cycle
      // lands behind a busy word only in the word modes
      pend_q <= pend_q && req_i && two_pend_i;
    end else if (req_i && (!busy_i || two_pend_i)) begin
      pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R12
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pend_o);

  // R10
  pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !two_pend_i && !pend_o && !start_i) |=> !pend_o);

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int CNT_W  = 8,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic [LINE_W-1:0] load_line_i,
  input  logic              line_start_i,
  input  logic              step_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              term_o,
  output logic              line_last_o
);

  localparam logic [CNT_W-1:0]  CNT_ZERO  = '0;
  localparam logic [LINE_W-1:0] LINE_ZERO = '0;

  logic [CNT_W-1:0]  orig_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LINE_W-1:0] line_len_q;
  logic [LINE_W-1:0] line_q;

  assign term_o      = (cnt_q == CNT_ZERO);
  assign line_last_o = (line_q == LINE_ZERO);
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_q <= CNT_ZERO;
      cnt_q  <= CNT_ZERO;
    end else if (load_i) begin
      orig_q <= load_cnt_i;
      cnt_q  <= load_cnt_i;
    end else if (step_i) begin
      cnt_q  <= term_o ? orig_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_len_q <= LINE_ZERO;
      line_q     <= LINE_ZERO;
    end else begin
      if (load_i) line_len_q <= load_line_i;
      if (line_start_i) line_q <= line_len_q;
      else if (step_i && !line_last_o) line_q <= line_q - 1'b1;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= orig_q);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !term_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && term_o && !load_i) |=> (cnt_q == orig_q));

endmodule

// File: rtl/dma_mode_seq.sv
module dma_mode_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [2:0]        cfg_mode,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic              irq_en,
  input  logic              req,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic              en_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_eob
);

  logic [2:0] mode_q;
  logic       en_q;
  logic       busy_q;
  logic       irq_q;

  mode_attr_t attr;
  logic       pend;
  logic       term;
  logic       line_last;
  logic       hs;
  logic       load;
  logic       clr;
  logic       trig;
  logic       start;
  logic       burst_last;
  logic       burst_end;

  dma_mode_decode u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_q),
    .attr_o (attr)
  );

  dma_req_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_q),
    .legal_i    (attr.legal),
    .req_trig_i (attr.req_trig),
    .two_pend_i (attr.two_pend),
    .busy_i     (busy_q),
    .start_i    (start),
    .req_i      (req),
    .pend_o     (pend)
  );

  dma_xfer_counter #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .load_cnt_i   (cfg_count),
    .load_line_i  (cfg_line),
    .line_start_i (start),
    .step_i       (hs),
    .cnt_o        (count_o),
    .term_o       (term),
    .line_last_o  (line_last)
  );

  assign hs    = busy_q && xfer_ready;
  assign load  = cfg_we && cfg_en && !en_q && !busy_q;
  assign clr   = cfg_we && !cfg_en && en_q;
  assign trig  = attr.req_trig ? (pend || req) : 1'b1;
  assign start = en_q && !busy_q && attr.legal && trig;

  always_comb begin
    case (attr.gran)
      GRAN_WORD: burst_last = 1'b1;
      GRAN_LINE: burst_last = line_last || term;
      default:   burst_last = term;
    endcase
  end

  // an aborted channel stops after the word in service
  assign burst_end = hs && (burst_last || !en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_BLK_REQ;
      en_q   <= 1'b0;
    end else if (load) begin
      mode_q <= cfg_mode;
      en_q   <= 1'b1;
    end else if (clr) begin
      en_q   <= 1'b0;
    end else if (hs && term && attr.auto_clr) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (start) busy_q <= 1'b1;
      else if (burst_end) busy_q <= 1'b0;
      irq_q <= hs && term && attr.auto_clr && irq_en;
    end
  end

  assign xfer_valid = busy_q;
  assign en_o       = en_q;
  assign irq_eob    = irq_q;

  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> xfer_valid);

  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (mode_q[2:1] != 2'b11));

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eob |=> !irq_eob);

  // R11
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eob |-> (!mode_q[2] && $past(xfer_valid) && $past(xfer_ready)));

  // R13
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q || busy_q) |=> (mode_q == $past(mode_q)));

  // R6
  enable_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !busy_q && mode_q == MODE_BLK_EN) |=> xfer_valid);

endmodule

// File: tb/dma_mode_seq_bench.sv
module dma_mode_seq_bench;

  localparam int CNT_W  = 8;
  localparam int LINE_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_en = 1'b0;
  logic [2:0]        cfg_mode = 3'd0;
  logic [CNT_W-1:0]  cfg_count = '0;
  logic [LINE_W-1:0] cfg_line = '0;
  logic              irq_en = 1'b0;
  logic              req = 1'b0;
  logic              xfer_valid;
  logic              xfer_ready;
  logic              en_o;
  logic [CNT_W-1:0]  count_o;
  logic              irq_eob;

  int vectors = 0;
  int fails = 0;
  int hs_n = 0;
  int irq_n = 0;
  int cyc = 0;
  bit bp = 1'b0;
  bit stall = 1'b0;

  dma_mode_seq #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_dma_mode_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_en     (cfg_en),
    .cfg_mode   (cfg_mode),
    .cfg_count  (cfg_count),
    .cfg_line   (cfg_line),
    .irq_en     (irq_en),
    .req        (req),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .en_o       (en_o),
    .count_o    (count_o),
    .irq_eob    (irq_eob)
  );

  always #5 clk = ~clk;

  assign xfer_ready = !stall && (!bp || (cyc % 3 != 0));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (xfer_valid && xfer_ready) hs_n++;
    if (irq_eob) irq_n++;
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic cfg_write(input bit en, input int mode, input int n, input int l);
    @(posedge clk);
    #1;
    cfg_we = 1'b1; cfg_en = en;
    cfg_mode = 3'(mode); cfg_count = CNT_W'(n); cfg_line = LINE_W'(l);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int width);
    @(posedge clk);
    #1;
    req = 1'b1;
    tick(width);
    req = 1'b0;
  endtask

  task automatic pulses(input int k, input int gap);
    for (int i = 0; i < k; i++) begin
      pulse(1);
      tick(gap);
    end
  endtask

  task automatic quiesce();
    cfg_write(1'b0, 0, 0, 0);
    tick(20);
    hs_n = 0;
    irq_n = 0;
  endtask

  task automatic scenario(input int mode, input int n, input int l, input bit ie);
    int ew, ei, een, ec, lines;
    string tag;
    irq_en = ie;
    quiesce();
    cfg_write(1'b1, mode, n, l);
    ew = n + 1; ei = ie ? 1 : 0; een = 0; ec = n;
    case (mode)
      0: begin pulses(2, 30); tag = "R3"; end
      1: begin pulses(n + 2, 8); tag = "R4"; end
      2: begin
        lines = (n + 1 + l) / (l + 1);
        pulses(lines + 1, 12);
        tag = "R5";
      end
      3: begin tick(30); tag = "R6"; end
      4: begin pulses(2, 30); ew = 2 * (n + 1); ei = 0; een = 1; tag = "R7"; end
      5: begin
        pulses(n + 2, 8);
        ew = n + 2; ei = 0; een = 1; ec = n - ((n + 2) % (n + 1));
        tag = "R8";
      end
      default: begin pulses(2, 10); ew = 0; ei = 0; een = 1; tag = "R9"; end
    endcase
    tick(40);
    check({tag, " words"}, hs_n, ew);
    check({tag, " R11 irq"}, irq_n, ei);
    check({tag, " enable"}, int'(en_o), een);
    check({tag, " count"}, int'(count_o), ec);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 enable", int'(en_o), 0);
    check("R1 count", int'(count_o), 0);
    check("R1 valid", int'(xfer_valid), 0);
    check("R1 irq", int'(irq_eob), 0);
    rst_n = 1'b1;
    tick(2);
    check("R1 idle after reset", int'(xfer_valid), 0);

    // sweep every mode, count, line length, irq enable and ready pattern
    for (int b = 0; b < 2; b++) begin
      bp = b[0];
      for (int m = 0; m < 8; m++)
        for (int n = 0; n < 4; n++)
          for (int l = 0; l < 2; l++)
            for (int ie = 0; ie < 2; ie++)
              scenario(m, n, l, ie[0]);
    end
    bp = 1'b0;

    // R10 word modes keep one request behind a busy word
    irq_en = 1'b0;
    quiesce();
    cfg_write(1'b1, 1, 3, 0);
    pulse(2);
    tick(20);
    check("R10 mode001 back-to-back words", hs_n, 2);
    check("R10 mode001 count", int'(count_o), 1);
    quiesce();
    cfg_write(1'b1, 5, 3, 0);
    pulse(2);
    tick(20);
    check("R10 mode101 back-to-back words", hs_n, 2);
    // R10 block repeat mode drops request arriving while busy
    quiesce();
    cfg_write(1'b1, 4, 3, 0);
    pulse(2);
    tick(30);
    check("R10 mode100 second request dropped", hs_n, 4);
    // R10 line mode drops request arriving while busy
    quiesce();
    cfg_write(1'b1, 2, 5, 1);
    pulse(2);
    tick(20);
    check("R10 mode010 second request dropped", hs_n, 2);

    // R3 request before enable is discarded
    quiesce();
    pulse(1);
    tick(2);
    cfg_write(1'b1, 0, 2, 0);
    tick(30);
    check("R3 early request ignored", hs_n, 0);
    pulse(1);
    tick(30);
    check("R3 request after enable", hs_n, 3);

    // R13 write while enabled is ignored
    quiesce();
    cfg_write(1'b1, 4, 2, 0);
    cfg_write(1'b1, 0, 5, 0);
    check("R13 count kept", int'(count_o), 2);
    pulse(1);
    tick(30);
    check("R13 mode kept words", hs_n, 3);
    check("R13 mode kept enable", int'(en_o), 1);

    // R12 abort while port stalled
    irq_en = 1'b1;
    quiesce();
    stall = 1'b1;
    cfg_write(1'b1, 3, 3, 0);
    tick(3);
    check("R2 valid raised under stall", int'(xfer_valid), 1);
    cfg_write(1'b0, 0, 0, 0);
    tick(2);
    check("R12 enable cleared at once", int'(en_o), 0);
    check("R12 word held", int'(xfer_valid), 1);
    stall = 1'b0;
    tick(10);
    check("R12 one word after abort", hs_n, 1);
    check("R12 no reload", int'(count_o), 2);
    check("R12 no irq", irq_n, 0);

    // R11 pulse timing, mode 011 with N=0
    quiesce();
    cfg_write(1'b1, 3, 0, 0);
    @(negedge clk);
    check("R11 no valid before start", int'(xfer_valid), 0);
    @(negedge clk);
    check("R2 valid in start cycle", int'(xfer_valid), 1);
    check("R11 irq not early", int'(irq_eob), 0);
    @(negedge clk);
    check("R11 irq after terminal handshake", int'(irq_eob), 1);
    check("R6 enable cleared", int'(en_o), 0);
    @(negedge clk);
    check("R11 irq one cycle", int'(irq_eob), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule